// File: doc/BRIEF.md
# Self-Stalling Functional Unit Pipeline

This block models the timing of one execution unit inside a processor core. Each instruction carries a tag and an operation class. An instruction is accepted only when three things hold: the unit supports its class, enough cycles have passed since the last accepted instruction, and the first pipeline slot can take a new entry. An accepted instruction moves down a chain of slots, one slot per cycle. Empty slots move along the chain as bubbles.

When a valid instruction reaches the final slot, that slot keeps it. The whole chain then stops until the commit side takes it, so the instruction waits at the end of the unit for as long as commit needs. Any issue request that is refused is dropped and reported on an error output for one cycle. The arithmetic itself, result forwarding and register scoreboarding belong to other blocks.

The unit is configured with three parameters:
- `OP_LAT`: the operation latency, which is also the number of slots.
- `ISSUE_LAT`: the minimum spacing between two accepted instructions.
- `CAPS`: a 32-bit capability mask, one bit per operation class.

Top module: `fu_pipe`

## Requirements
- R1: During and straight after the synchronous active-low reset, `head_valid` and `iss_err` are 0, every slot holds a bubble, and `can_issue` is 1.
- R2: A request whose class is `c` (0 to 31) is accepted only when bit `c` of `CAPS` is 1. When that bit is 0 the request is dropped, and `iss_err` is 1 in the next cycle.
- R3: After an instruction is accepted, `can_issue` stays 0 for the next `ISSUE_LAT-1` cycles. With `ISSUE_LAT=1`, back-to-back issue is allowed.
- R4: An instruction accepted in cycle c appears in cycle c+`OP_LAT` with `head_valid`=1 and its own tag, provided the chain does not stall. Instructions leave in issue order. Cycles with no accepted instruction come out as cycles with `head_valid`=0.
- R5: While `head_valid`=1 and `head_take`=0, the chain does not move: `head_valid` and `head_tag` hold, and so does every slot behind the head.
- R6: When `head_take`=1 in a cycle where `head_valid`=1, the chain advances at the end of that same cycle.
- R7: `can_issue` is 1 only when the spacing count has expired and the first slot is free at the next edge. The first slot is free either because the chain is advancing or because it holds a bubble. A bubble in the first slot is filled even while the chain stalls.
- R8: A request made while `can_issue`=0 is dropped: the slots, and therefore `head_valid` and `head_tag`, are unaffected by it. `iss_err` is 1 in the next cycle, and only then. An accepted request never raises `iss_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Issue request this cycle |
| iss_tag | input | TAG_W | Tag of the instruction offered |
| iss_class | input | 5 | Operation class of the instruction offered |
| can_issue | output | 1 | A supported request made now would be accepted |
| iss_err | output | 1 | The request of the previous cycle was refused |
| head_valid | output | 1 | The final slot holds an instruction |
| head_tag | output | TAG_W | Tag of the instruction in the final slot |
| head_take | input | 1 | Commit removes the head instruction this cycle |

## Verification
Two results depend on the current inputs and are checked before the edge:
- `can_issue` is purely combinational. It is checked one time unit after the inputs are driven.
- The decision to accept or refuse is made at that same edge, from the same inputs.

The remaining results are registered and are checked at the falling edge that follows:
- `iss_err` is due one edge after the request.
- `head_valid` and `head_tag` move one slot per advancing edge, so an undisturbed instruction reaches the head `OP_LAT` edges after it is accepted.

A behavioural model in the bench keeps the slot contents and the spacing count as plain integers. It is stepped once per rising edge with the same inputs as the design, so stalls, takes and refusals shift the expected values by exactly the cycles they cost.

// File: rtl/fu_pipe_pkg.sv
// Package: shared constants for the functional-unit pipeline.
// Assumes classes are numbered 0..FU_NUM_CLASSES-1.
package fu_pipe_pkg;
    localparam int unsigned FU_NUM_CLASSES = 32;
    localparam int unsigned FU_CLASS_W     = $clog2(FU_NUM_CLASSES);
    localparam int unsigned FU_DEF_TAG_W   = 8;
endpackage

// File: rtl/fu_issue_gate.sv
// Issue gate: decides acceptance from the class mask, the spacing count
// and the availability of the first slot; flags refused requests.
// Assumes slot0_free is valid in the same cycle as iss_valid.
module fu_issue_gate
    import fu_pipe_pkg::*;
#(
    parameter int unsigned             ISSUE_LAT = 2,
    parameter logic [FU_NUM_CLASSES-1:0] CAPS    = 32'h0000_F0F5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [FU_CLASS_W-1:0] iss_class,
    input  logic                  slot0_free,
    output logic                  can_issue,
    output logic                  accept,
    output logic                  iss_err
);
    localparam int unsigned CNT_W = (ISSUE_LAT > 1) ? $clog2(ISSUE_LAT) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ISSUE_LAT - 1);

    logic [CNT_W-1:0] gap_cnt;
    logic             class_ok;

    // Combine spacing, slot availability and capability into the accept decision.
    always_comb begin
        class_ok  = CAPS[iss_class];
        can_issue = (gap_cnt == '0) && slot0_free;
        accept    = iss_valid && can_issue && class_ok;
    end

    // Spacing counter: reloads on accept, counts down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (accept) begin
            gap_cnt <= RELOAD;
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // One-cycle refusal flag for any request that was not accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) iss_err <= 1'b0;
        else        iss_err <= iss_valid && !accept;
    end
endmodule

// File: rtl/fu_slot_chain.sv
// Slot chain: OP_LAT slots of {valid, tag}; advances one slot per cycle
// unless a valid head is waiting for commit. Slot 0 can be filled while
// stalled if it holds a bubble. Assumes accept only when slot0_free.
module fu_slot_chain #(
    parameter int unsigned OP_LAT = 4,
    parameter int unsigned TAG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             head_take,
    output logic             slot0_free,
    output logic             head_valid,
    output logic [TAG_W-1:0] head_tag
);
    localparam int unsigned LAST = OP_LAT - 1;

    logic [OP_LAT-1:0] vld;
    logic [TAG_W-1:0]  tag [OP_LAT];
    logic              stall;

    // Stall when the head holds an instruction commit has not taken.
    always_comb begin
        stall      = vld[LAST] && !head_take;
        slot0_free = !stall || !vld[0];
        head_valid = vld[LAST];
        head_tag   = tag[LAST];
    end

    // First slot: load on accept, else take a bubble when advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld[0] <= 1'b0;
            tag[0] <= '0;
        end else if (accept) begin
            vld[0] <= 1'b1;
            tag[0] <= in_tag;
        end else if (!stall) begin
            vld[0] <= 1'b0;
        end
    end

    // Remaining slots: copy from the slot ahead when not stalled.
    for (genvar i = 1; i < OP_LAT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                tag[i] <= '0;
            end else if (!stall) begin
                vld[i] <= vld[i-1];
                tag[i] <= tag[i-1];
            end
        end
    end
endmodule

// File: rtl/fu_pipe.sv
// Top: one functional unit as a self-stalling slot pipeline with an
// issue gate in front. Assumes 1 <= OP_LAT <= 8 and 1 <= ISSUE_LAT <= 8.
module fu_pipe
    import fu_pipe_pkg::*;
#(
    parameter int unsigned               OP_LAT    = 4,
    parameter int unsigned               ISSUE_LAT = 2,
    parameter int unsigned               TAG_W     = FU_DEF_TAG_W,
    parameter logic [FU_NUM_CLASSES-1:0] CAPS      = 32'h0000_F0F5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_valid,
    input  logic [TAG_W-1:0]      iss_tag,
    input  logic [FU_CLASS_W-1:0] iss_class,
    output logic                  can_issue,
    output logic                  iss_err,
    output logic                  head_valid,
    output logic [TAG_W-1:0]      head_tag,
    input  logic                  head_take
);
    logic slot0_free;
    logic accept;

    fu_issue_gate #(
        .ISSUE_LAT (ISSUE_LAT),
        .CAPS      (CAPS)
    ) gate_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_class  (iss_class),
        .slot0_free (slot0_free),
        .can_issue  (can_issue),
        .accept     (accept),
        .iss_err    (iss_err)
    );

    fu_slot_chain #(
        .OP_LAT (OP_LAT),
        .TAG_W  (TAG_W)
    ) chain_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .in_tag     (iss_tag),
        .head_take  (head_take),
        .slot0_free (slot0_free),
        .head_valid (head_valid),
        .head_tag   (head_tag)
    );
endmodule

// File: rtl/fu_pipe_chk.sv
// Checker: port-level timing properties of fu_pipe, bound to every instance.
module fu_pipe_chk
    import fu_pipe_pkg::*;
#(
    parameter int unsigned               ISSUE_LAT = 2,
    parameter int unsigned               TAG_W     = 8,
    parameter logic [FU_NUM_CLASSES-1:0] CAPS      = 32'h0000_F0F5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  iss_valid,
    input logic [FU_CLASS_W-1:0] iss_class,
    input logic                  can_issue,
    input logic                  iss_err,
    input logic                  head_valid,
    input logic [TAG_W-1:0]      head_tag,
    input logic                  head_take
);
    assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid && !head_take |=> head_valid && $stable(head_tag));

    assert_bad_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && can_issue && !CAPS[iss_class] |=> iss_err);

    assert_blocked_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !can_issue |=> iss_err);

    assert_no_err_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && can_issue && CAPS[iss_class] |=> !iss_err);

    assert_idle_no_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |=> !iss_err);

    if (ISSUE_LAT > 1) begin : g_gap
        assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid && can_issue && CAPS[iss_class] |=> !can_issue);
    end
endmodule

bind fu_pipe fu_pipe_chk #(
    .ISSUE_LAT (ISSUE_LAT),
    .TAG_W     (TAG_W),
    .CAPS      (CAPS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_class  (iss_class),
    .can_issue  (can_issue),
    .iss_err    (iss_err),
    .head_valid (head_valid),
    .head_tag   (head_tag),
    .head_take  (head_take)
);

// File: tb/fu_pipe_tb_top.sv
module fu_pipe_tb_top;
    localparam int    OP_LAT    = 4;
    localparam int    ISSUE_LAT = 2;
    localparam int    TAG_W     = 8;
    localparam logic [31:0] CAPS = 32'h0000_F0F5;
    localparam time   HALF      = 5ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic [4:0]       iss_class = '0;
    logic             can_issue;
    logic             iss_err;
    logic             head_valid;
    logic [TAG_W-1:0] head_tag;
    logic             head_take = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_vld [OP_LAT];
    int m_tag [OP_LAT];
    int m_cnt = 0;
    int m_err = 0;

    always #HALF clk = ~clk;

    fu_pipe #(.OP_LAT(OP_LAT), .ISSUE_LAT(ISSUE_LAT), .TAG_W(TAG_W), .CAPS(CAPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_tag(iss_tag),
        .iss_class(iss_class), .can_issue(can_issue), .iss_err(iss_err),
        .head_valid(head_valid), .head_tag(head_tag), .head_take(head_take)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_ci();
        int stall = (m_vld[OP_LAT-1] != 0) && head_take;
        stall = (m_vld[OP_LAT-1] != 0) && !head_take;
        return (m_cnt == 0 && (!stall || m_vld[0] == 0)) ? 1 : 0;
    endfunction

    task automatic model_step();
        int stall = (m_vld[OP_LAT-1] != 0) && !head_take;
        int acc   = iss_valid && model_ci() && CAPS[iss_class];
        m_err = (iss_valid && !acc) ? 1 : 0;
        if (!stall) begin
            for (int i = OP_LAT-1; i > 0; i--) begin
                m_vld[i] = m_vld[i-1];
                m_tag[i] = m_tag[i-1];
            end
            m_vld[0] = 0;
        end
        if (acc) begin
            m_vld[0] = 1;
            m_tag[0] = int'(iss_tag);
        end
        if (acc) m_cnt = ISSUE_LAT - 1;
        else if (m_cnt > 0) m_cnt--;
    endtask

    // one cycle: drive at negedge, check combinational, step, check registered
    task automatic cyc(bit v, int tg, int cls, bit take);
        iss_valid = v;
        iss_tag   = TAG_W'(tg);
        iss_class = 5'(cls);
        head_take = take;
        #1;
        check("R3 R7 can_issue", int'(can_issue), model_ci());
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R2 R8 iss_err", int'(iss_err), m_err);
        check("R4 R5 R6 head_valid", int'(head_valid), m_vld[OP_LAT-1]);
        if (m_vld[OP_LAT-1] != 0)
            check("R4 R5 R6 head_tag", int'(head_tag), m_tag[OP_LAT-1]);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < OP_LAT; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 head_valid", int'(head_valid), 0);
        check("R1 iss_err", int'(iss_err), 0);
        check("R1 can_issue", int'(can_issue), 1);
        rst_n = 1'b1;
        // R2: every class offered once, commit always taking
        for (int c = 0; c < 32; c++) cyc(1'b1, c + 1, c, 1'b1);
        for (int k = 0; k < OP_LAT + 2; k++) cyc(1'b0, 0, 0, 1'b1);
        // R5 R7: fill then stall with requests every cycle
        for (int k = 0; k < 14; k++) cyc(1'b1, 100 + k, 0, 1'b0);
        // R6: release one at a time, then drain
        for (int k = 0; k < 6; k++) cyc(1'b1, 120 + k, 2, k[0]);
        for (int k = 0; k < OP_LAT * 3; k++) cyc(1'b0, 0, 0, 1'b1);
        // mixed pseudo-random traffic
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], int'(lfsr[15:8]), int'(lfsr[6:2]), lfsr[7] | lfsr[1]);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule